// File: doc/BRIEF.md
# Branch Target History Queue

This block keeps a short debug history of where the core went after its most recent taken branches. When the core reports a taken branch, it also gives the first fetch address after that branch. The low address bits of that address enter the head of an eight-deep shift queue, and each slot carries its own valid flag. Older slots move one step deeper, and the deepest slot drops out.

A debug agent reads the history through a single read-only word. Each read returns the head slot, which has the valid flag on top, three zero bits and the stored address at the bottom. The read also consumes that slot: the queue advances so that repeated reads walk from newest to oldest, and an invalid slot fills the tail. The read word is registered and appears one cycle after the read strobe.

The block has two resets, one for power-on and one for manual reset. Either of them clears every valid flag. Neither of them touches the stored address bits, so addresses captured before a reset can still be read afterwards, flagged invalid.

Top module: `branchTraceQueue`

## Requirements
- R1: The queue holds 8 slots. A branch moves every slot one step deeper and drops the deepest slot, so after 9 or more branches only the 8 newest can be read back.
- R2: The read word carries the valid flag in bit 31 and the low 28 bits of the branch target in bits 27..0. Bits 30..28 always read as 0, and target bits 31..28 are discarded.
- R3: A branch strobe writes its target into the head slot with the valid flag set to 1.
- R4: A read returns the head slot and advances the queue by one, so that successive reads return the newest to the oldest entry. Each read fills the tail slot with an invalid entry, so once the captured entries are used up, reads return bit 31 = 0.
- R5: If a branch strobe and a read occur in the same cycle, the read returns the head slot as it stood before the branch. The new branch then replaces that head slot as a valid entry, and the deeper slots do not move.
- R6: The read word appears on `rdData` in the cycle after the read strobe, and it holds its value until the next read.
- R7: A bus write (`busSel` = 1 with `busWrite` = 1) changes no slot and leaves `rdData` unchanged.
- R8: Power-on reset (`porRstN` = 0) clears every valid flag and clears `rdData` to 0. It keeps the stored address bits, which a later read returns with bit 31 = 0.
- R9: Manual reset (`manRstN` = 0) clears every valid flag in the same way and also keeps the stored address bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| manRstN | input | 1 | Manual reset, active low, asynchronous |
| brValid | input | 1 | One-cycle strobe for a taken branch |
| brTarget | input | 32 | First fetch address after the branch |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write attempt (ignored), 0 = read |
| rdData | output | 32 | Registered read word |

## Verification
The assertions assume that `brValid` and `busSel` are single-cycle strobes sampled on the clock edge. They also assume that no read is pending while either reset is asserted, since a reset clears `rdData`. They further assume that `busWrite` has meaning only while `busSel` is high. The stimulus drives every strobe on the falling edge and holds it for one cycle. Each reset is applied only in idle cycles, after any read word has already been compared. Both branch-only and read-only cycles are exercised, as well as combined branch-and-read cycles and write attempts mixed between reads.

// File: rtl/traceQueuePkg.sv
package traceQueuePkg;
  // control strobes from the sequencer to the slot storage
  typedef struct packed {
    logic push;      // branch only: shift deeper, new head
    logic pop;       // read only: shift toward head, invalid tail
    logic swapHead;  // branch and read together: replace head only
    logic load;      // capture head into the read register
  } ctrl_t;
endpackage

// File: rtl/traceQueueCtrl.sv
module traceQueueCtrl
  import traceQueuePkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  brValid,
  input  logic  busSel,
  input  logic  busWrite,
  output ctrl_t ctrl
);

  logic readReq;
  logic writeReq;

  assign readReq  = busSel & ~busWrite;
  assign writeReq = busSel & busWrite;

  always_comb begin
    ctrl          = '0;
    ctrl.load     = readReq;
    ctrl.push     = brValid & ~readReq;
    ctrl.pop      = readReq & ~brValid;
    ctrl.swapHead = brValid & readReq;
  end

  // R5
  ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.push, ctrl.pop, ctrl.swapHead}));

  // R7
  write_noop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (writeReq && !brValid) |-> !(ctrl.load || ctrl.pop || ctrl.push || ctrl.swapHead));

endmodule

// File: rtl/traceQueueData.sv
module traceQueueData
  import traceQueuePkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] newAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int FLAG_BIT = DATA_W - 1;
  localparam int PAD_W    = DATA_W - 1 - ADDR_W;
  localparam int LAST     = DEPTH - 1;

  logic              validQ [DEPTH];
  logic [ADDR_W-1:0] addrQ  [DEPTH];
  logic [DEPTH-1:0]  validVec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam int PREV = (i == 0) ? 0 : i - 1;
    localparam int NEXT = (i == LAST) ? i : i + 1;
    logic              nextV;
    logic [ADDR_W-1:0] nextA;

    always_comb begin
      nextV = validQ[i];
      nextA = addrQ[i];
      if (ctrl.push) begin
        if (i == 0) begin
          nextV = 1'b1;
          nextA = newAddr;
        end else begin
          nextV = validQ[PREV];
          nextA = addrQ[PREV];
        end
      end else if (ctrl.swapHead) begin
        if (i == 0) begin
          nextV = 1'b1;
          nextA = newAddr;
        end
      end else if (ctrl.pop) begin
        if (i == LAST) begin
          nextV = 1'b0;
        end else begin
          nextV = validQ[NEXT];
          nextA = addrQ[NEXT];
        end
      end
    end

    // flags follow both resets
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ[i] <= 1'b0;
      else       validQ[i] <= nextV;
    end

    // addresses survive reset
    always_ff @(posedge clk) begin
      addrQ[i] <= nextA;
    end

    assign validVec[i] = validQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (ctrl.load) rdData <= {validQ[0], {PAD_W{1'b0}}, addrQ[0]};
  end

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[FLAG_BIT-1:ADDR_W] == '0);

  // R3
  capture_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.push || ctrl.swapHead) |=> (validQ[0] && addrQ[0] == $past(newAddr)));

  // R1
  shift_deep_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.push |=> (validQ[LAST] == $past(validQ[LAST-1])));

  // R4
  pop_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pop |=> (validQ[0] == $past(validQ[1]) && !validQ[LAST]));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(rdData));

  // R8
  always_ff @(posedge clk) begin
    if (!rstN) reset_flags_chk: assert (validVec == '0);
  end

endmodule

// File: rtl/branchTraceQueue.sv
module branchTraceQueue
  import traceQueuePkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRstN,
  input  logic              brValid,
  input  logic [DATA_W-1:0] brTarget,
  input  logic              busSel,
  input  logic              busWrite,
  output logic [DATA_W-1:0] rdData
);

  logic  rstN;
  ctrl_t ctrl;
  logic  unusedHigh;

  assign rstN       = porRstN & manRstN;
  assign unusedHigh = ^brTarget[DATA_W-1:ADDR_W];

  traceQueueCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .brValid  (brValid),
    .busSel   (busSel),
    .busWrite (busWrite),
    .ctrl     (ctrl)
  );

  traceQueueData #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .newAddr (brTarget[ADDR_W-1:0]),
    .rdData  (rdData)
  );

endmodule

// File: tb/sim_branchTraceQueue.sv
module sim_branchTraceQueue;

  typedef struct {
    logic [31:0] word;
    logic [31:0] mask;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        manRstN = 1'b0;
  logic        brValid = 1'b0;
  logic [31:0] brTarget = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] rdData;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  exp_t sbQ[$];
  logic        mV [8];
  logic [27:0] mA [8];
  bit          mK [8];
  logic        rdPend = 1'b0;

  always #5 clk = ~clk;

  branchTraceQueue u0 (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .brValid(brValid),
    .brTarget(brTarget), .busSel(busSel), .busWrite(busWrite), .rdData(rdData)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input logic [31:0] mask, input string tag);
    nChecks++;
    if ((act & mask) !== (exp & mask)) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h (mask %h)", tag, act, exp, mask);
    end
  endtask

  // driver: one cycle of stimulus, model update, expected push
  task automatic cyc(input logic br, input logic [31:0] tgt,
                     input logic sel, input logic wr, input string tag);
    exp_t e;
    bit rd;
    rd = sel && !wr;
    brValid = br; brTarget = tgt; busSel = sel; busWrite = wr;
    if (rd) begin
      e.word = {mV[0], 3'b000, mA[0]};
      e.mask = (mV[0] || mK[0]) ? 32'hFFFF_FFFF : 32'hF000_0000;
      e.tag  = tag;
      sbQ.push_back(e);
    end
    if (br && rd) begin
      mV[0] = 1'b1; mA[0] = tgt[27:0]; mK[0] = 1;
    end else if (br) begin
      for (int i = 7; i > 0; i--) begin
        mV[i] = mV[i-1]; mA[i] = mA[i-1]; mK[i] = mK[i-1];
      end
      mV[0] = 1'b1; mA[0] = tgt[27:0]; mK[0] = 1;
    end else if (rd) begin
      for (int i = 0; i < 7; i++) begin
        mV[i] = mV[i+1]; mA[i] = mA[i+1]; mK[i] = mK[i+1];
      end
      mV[7] = 1'b0; mK[7] = 0;
    end
    @(negedge clk);
    brValid = 1'b0; busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseReset(input bit manual);
    if (manual) manRstN = 1'b0; else porRstN = 1'b0;
    @(negedge clk);
    manRstN = 1'b1; porRstN = 1'b1;
    for (int i = 0; i < 8; i++) mV[i] = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) rdPend <= busSel && !busWrite;

  always @(negedge clk) begin
    if (rdPend) begin
      if (sbQ.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL R6: unexpected read word %h, expected none", rdData);
      end else begin
        exp_t e;
        e = sbQ.pop_front();
        check(rdData, e.word, e.mask, e.tag);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] held;
    for (int i = 0; i < 8; i++) begin mV[i] = 0; mA[i] = '0; mK[i] = 0; end
    idle(3);
    porRstN = 1'b1; manRstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(rdData, 32'h0, 32'hFFFF_FFFF, "R8 reset rdData");

    // R4 empty read shows invalid
    cyc(0, 0, 1, 0, "R4 empty read");
    idle(1);

    // R3 R2 R4 three branches then drain
    cyc(1, 32'h0000_1000, 0, 0, "");
    cyc(1, 32'h0000_2004, 0, 0, "");
    cyc(1, 32'hF123_4568, 0, 0, "");
    cyc(0, 0, 1, 0, "R2 R3 newest with high bits dropped");
    cyc(0, 0, 1, 0, "R4 second newest");
    cyc(0, 0, 1, 0, "R4 oldest");
    cyc(0, 0, 1, 0, "R4 drained invalid");
    idle(1);

    // R1 ten branches, nine reads
    for (int k = 0; k < 10; k++) cyc(1, 32'hA000_0000 + k * 32'h10, 0, 0, "");
    for (int k = 0; k < 9; k++) cyc(0, 0, 1, 0, (k < 8) ? "R1 eight newest" : "R1 ninth dropped");
    idle(1);

    // R5 simultaneous branch and read
    cyc(1, 32'h0000_0111, 0, 0, "");
    cyc(1, 32'h0000_0222, 0, 0, "");
    cyc(1, 32'h0000_0333, 1, 0, "R5 read returns pre-branch head");
    cyc(0, 0, 1, 0, "R5 new branch at head");
    cyc(0, 0, 1, 0, "R5 deeper slot unmoved");
    cyc(0, 0, 1, 0, "R5 then invalid");
    idle(1);

    // R6 hold between reads, R7 writes ignored
    cyc(1, 32'h0555_5550, 0, 0, "");
    cyc(1, 32'h0AAA_AAA0, 0, 0, "");
    cyc(0, 0, 1, 0, "R6 latency");
    held = rdData;
    cyc(0, 32'hFFFF_FFFF, 1, 1, "");
    cyc(0, 0, 1, 1, "");
    idle(2);
    check(rdData, held, 32'hFFFF_FFFF, "R6 R7 rdData held across writes");
    cyc(0, 0, 1, 0, "R7 older slot intact after writes");
    cyc(0, 0, 1, 0, "R7 no extra entry");
    idle(1);

    // R9 manual reset keeps addresses, clears flags
    cyc(1, 32'h0123_4560, 0, 0, "");
    cyc(1, 32'h0765_4320, 0, 0, "");
    idle(1);
    pulseReset(1);
    cyc(0, 0, 1, 0, "R9 head invalid addr kept");
    cyc(0, 0, 1, 0, "R9 second invalid addr kept");
    idle(1);

    // R8 power-on reset same behaviour
    cyc(1, 32'h0BAD_C0D0, 0, 0, "");
    idle(1);
    pulseReset(0);
    check(rdData, 32'h0, 32'hFFFF_FFFF, "R8 rdData cleared");
    cyc(0, 0, 1, 0, "R8 head invalid addr kept");
    idle(2);
    if (sbQ.size() != 0) begin
      nChecks++; nFail++;
      $display("FAIL R6: actual %0d pending reads expected 0", sbQ.size());
    end
    finish();
  end

endmodule